// File: doc/BRIEF.md
# SDRAM Mode Register Tracker

This block sits beside the command and address pins of a mobile DDR SDRAM interface and follows every mode register write the controller issues. When it sees such a write, it captures the address bus. It then turns the burst length code, the burst ordering bit and the read latency code into separate registered outputs that the rest of the controller or a protocol monitor can use directly.

The block also checks whether each write is legal. A write counts only when every bank is idle, when both bank address bits are low, and when no other command follows too closely. Any broken rule sets a sticky error flag. An accepted write keeps the tracker busy for two cycles. When the write completes, the block sends a one-cycle pulse to tell downstream logic that the extended mode register has gone back to its default.

Top module: `sdram_mode_tracker`

## Requirements
- R1: A mode register write is recognised on a rising clock edge when cs_n, ras_n, cas_n and we_n are all 0 and cke is 1 on that edge and was also 1 on the previous edge. Any other combination captures nothing.
- R2: The address bus is captured on the edge that recognises an accepted write. The decoded outputs change in the cycle that follows that edge.
- R3: Burst length comes from addr[2:0]. Code 1 gives 2, code 2 gives 4, code 3 gives 8 and code 4 gives 16. Any other code loads 0 and sets err_reserved.
- R4: addr[3] loads burst_interleave. 0 selects sequential order and 1 selects interleaved order.
- R5: Read latency comes from addr[6:4]. Code 2 gives 2 and code 3 gives 3. Any other code loads 0 and sets err_reserved.
- R6: If any bit of addr[12:7] is 1 on an accepted write, err_test is set. The write is still accepted.
- R7: A recognised write with ba not equal to 0 (and banks idle, tracker not busy) sets err_bank_addr. The write is rejected and all outputs keep their values.
- R8: A recognised write while banks_idle is 0 (tracker not busy) sets err_bank_state. The write is rejected and all outputs keep their values.
- R9: mr_busy is 1 for exactly the two cycles that follow the edge of each accepted write.
- R10: A non-idle command is sampled while mr_busy is 1 when cs_n is 0 and ras_n, cas_n and we_n are not all 1. Such a command sets err_timing and is ignored, even if it is a mode register write.
- R11: emr_reset is a single-cycle pulse during the second busy cycle of each accepted write.
- R12: After reset, mr_valid is 0 until the first accepted write. From then on it stays 1 until the next reset.
- R13: All error flags are sticky until clr_err is sampled 1. A clear wins over a set on the same edge. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Clears all sticky error flags |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (13) | Address bus |
| ba | input | BA_W (2) | Bank address |
| banks_idle | input | 1 | All banks are in the idle state |
| mr_valid | output | 1 | Register holds a written value |
| burst_len | output | BL_W (5) | Decoded burst length, 0 if reserved |
| burst_interleave | output | 1 | 1 = interleaved, 0 = sequential |
| read_lat | output | RL_W (2) | Decoded read latency, 0 if reserved |
| mr_busy | output | 1 | Write in progress |
| emr_reset | output | 1 | Extended register return-to-default pulse |
| err_timing | output | 1 | Command issued during a write |
| err_bank_state | output | 1 | Write issued with banks not idle |
| err_bank_addr | output | 1 | Write issued with nonzero bank address |
| err_reserved | output | 1 | Reserved burst length or latency code |
| err_test | output | 1 | Test-mode bits nonzero |

## Verification
The in-RTL assertions check several properties on every cycle. mr_busy always lasts exactly two cycles, and emr_reset only appears in the second of them. mr_valid never falls outside reset. A command that arrives while busy, or a write issued with banks not idle, always raises its flag unless a clear is sampled on the same edge. Other behaviours only show up in the bench scenarios, which compare every output each cycle against a behavioural model. These are the decode tables, the rejection of a write that arrives on the same edge cke rises, the write that is accepted despite test bits, and the precedence between a clear and a set.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int BL_LSB  = 0;
  localparam int BL_MSB  = 2;
  localparam int BT_BIT  = 3;
  localparam int RL_LSB  = 4;
  localparam int RL_MSB  = 6;
  localparam int TM_LSB  = 7;

  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} wr_phase_t;

  typedef struct packed {
    logic timing;
    logic bank_state;
    logic bank_addr;
    logic reserved;
    logic test;
  } err_flags_t;
endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic is_mrs,
  output logic is_active
);
  logic cke_prev;

  always_ff @(posedge clk) begin
    if (rst) cke_prev <= 1'b0;
    else     cke_prev <= cke;
  end

  // write needs cke high on this edge and the one before
  assign is_mrs    = cke && cke_prev && !cs_n && !ras_n && !cas_n && !we_n;
  // anything selected that is not a no-operation
  assign is_active = !cs_n && !(ras_n && cas_n && we_n);
endmodule

// File: rtl/mrs_field_decode.sv
module mrs_field_decode #(
  parameter int ADDR_W = 13,
  parameter int BL_W   = 5,
  parameter int RL_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BL_W-1:0]   bl_val,
  output logic              bt,
  output logic [RL_W-1:0]   rl_val,
  output logic              bl_rsvd,
  output logic              rl_rsvd,
  output logic              test_nz
);
  import mrs_pkg::*;
  localparam int BLC_W = BL_MSB - BL_LSB + 1;
  localparam int RLC_W = RL_MSB - RL_LSB + 1;

  logic [BLC_W-1:0] bl_code;
  logic [RLC_W-1:0] rl_code;

  assign bl_code = addr[BL_MSB:BL_LSB];
  assign rl_code = addr[RL_MSB:RL_LSB];
  assign bt      = addr[BT_BIT];
  assign test_nz = |addr[ADDR_W-1:TM_LSB];

  always_comb begin
    bl_rsvd = (bl_code == '0) || (bl_code > BLC_W'(4));
    bl_val  = bl_rsvd ? '0 : (BL_W'(1) << bl_code);
  end

  always_comb begin
    rl_rsvd = !(rl_code == RLC_W'(2) || rl_code == RLC_W'(3));
    rl_val  = rl_rsvd ? '0 : RL_W'(rl_code);
  end
endmodule

// File: rtl/mrs_write_seq.sv
module mrs_write_seq (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic busy,
  output logic emr_pulse
);
  import mrs_pkg::*;
  wr_phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else begin
      unique case (phase)
        PH_IDLE:   if (accept) phase <= PH_FIRST;
        PH_FIRST:  phase <= PH_SECOND;
        PH_SECOND: phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign emr_pulse = (phase == PH_SECOND);
endmodule

// File: rtl/sdram_mode_tracker.sv
module sdram_mode_tracker #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int BL_W   = 5,
  parameter int RL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_err,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-1:0]   ba,
  input  logic              banks_idle,
  output logic              mr_valid,
  output logic [BL_W-1:0]   burst_len,
  output logic              burst_interleave,
  output logic [RL_W-1:0]   read_lat,
  output logic              mr_busy,
  output logic              emr_reset,
  output logic              err_timing,
  output logic              err_bank_state,
  output logic              err_bank_addr,
  output logic              err_reserved,
  output logic              err_test
);
  import mrs_pkg::*;

  logic is_mrs, is_active;
  logic [BL_W-1:0] bl_d;
  logic [RL_W-1:0] rl_d;
  logic bt_d, bl_rsvd, rl_rsvd, test_nz;
  logic accept;
  err_flags_t err_q, err_set;

  mrs_cmd_decode u_cmd (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .is_mrs(is_mrs), .is_active(is_active)
  );

  mrs_field_decode #(.ADDR_W(ADDR_W), .BL_W(BL_W), .RL_W(RL_W)) u_fields (
    .addr(addr), .bl_val(bl_d), .bt(bt_d), .rl_val(rl_d),
    .bl_rsvd(bl_rsvd), .rl_rsvd(rl_rsvd), .test_nz(test_nz)
  );

  mrs_write_seq u_seq (
    .clk(clk), .rst(rst), .accept(accept),
    .busy(mr_busy), .emr_pulse(emr_reset)
  );

  assign accept = is_mrs && !mr_busy && banks_idle && (ba == '0);

  always_comb begin
    err_set.timing     = mr_busy && is_active;
    err_set.bank_state = is_mrs && !mr_busy && !banks_idle;
    err_set.bank_addr  = is_mrs && !mr_busy && banks_idle && (ba != '0);
    err_set.reserved   = accept && (bl_rsvd || rl_rsvd);
    err_set.test       = accept && test_nz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mr_valid         <= 1'b0;
      burst_len        <= '0;
      burst_interleave <= 1'b0;
      read_lat         <= '0;
    end else if (accept) begin
      mr_valid         <= 1'b1;
      burst_len        <= bl_d;
      burst_interleave <= bt_d;
      read_lat         <= rl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_err) err_q <= '0;
    else                err_q <= err_q | err_set;
  end

  assign err_timing     = err_q.timing;
  assign err_bank_state = err_q.bank_state;
  assign err_bank_addr  = err_q.bank_addr;
  assign err_reserved   = err_q.reserved;
  assign err_test       = err_q.test;

  // R9
  busy_two_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mr_busy) |=> mr_busy);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    (mr_busy && $past(mr_busy)) |=> !mr_busy);
  // R11
  emr_in_second_chk: assert property (@(posedge clk) disable iff (rst)
    emr_reset |-> (mr_busy && $past(mr_busy)));
  // R12
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mr_valid |=> mr_valid);
  // R10
  timing_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mr_busy && is_active && !clr_err) |=> err_timing);
  // R8
  bank_state_chk: assert property (@(posedge clk) disable iff (rst)
    (is_mrs && !mr_busy && !banks_idle && !clr_err) |=> err_bank_state);
  // R7
  bank_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (is_mrs && !mr_busy && banks_idle && ba != '0) |=> $stable(burst_len));
endmodule

// File: tb/test_sdram_mode_tracker.sv
module test_sdram_mode_tracker;
  logic clk = 0, rst = 1, clr_err = 0, cke = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, banks_idle = 1;
  logic [12:0] addr = '0;
  logic [1:0] ba = '0;
  logic mr_valid, burst_interleave, mr_busy, emr_reset;
  logic err_timing, err_bank_state, err_bank_addr, err_reserved, err_test;
  logic [4:0] burst_len;
  logic [1:0] read_lat;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_ph = 0, m_bl = 0, m_rl = 0;
  bit m_valid = 0, m_bt = 0, m_ckep = 0;
  bit e_tim = 0, e_bs = 0, e_ba = 0, e_rs = 0, e_ts = 0;

  sdram_mode_tracker i_sdram_mode_tracker (
    .clk(clk), .rst(rst), .clr_err(clr_err), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .banks_idle(banks_idle), .mr_valid(mr_valid), .burst_len(burst_len),
    .burst_interleave(burst_interleave), .read_lat(read_lat),
    .mr_busy(mr_busy), .emr_reset(emr_reset), .err_timing(err_timing),
    .err_bank_state(err_bank_state), .err_bank_addr(err_bank_addr),
    .err_reserved(err_reserved), .err_test(err_test)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    bit mrs, act, busy, acc;
    int blc, rlc;
    if (rst) begin
      m_ph = 0; m_bl = 0; m_rl = 0; m_valid = 0; m_bt = 0; m_ckep = 0;
      e_tim = 0; e_bs = 0; e_ba = 0; e_rs = 0; e_ts = 0;
    end else begin
      mrs  = cke && m_ckep && !cs_n && !ras_n && !cas_n && !we_n;
      act  = !cs_n && !(ras_n && cas_n && we_n);
      busy = (m_ph != 0);
      acc  = mrs && !busy && banks_idle && (ba == 0);
      blc = int'(addr[2:0]);
      rlc = int'(addr[6:4]);
      if (clr_err) begin
        e_tim = 0; e_bs = 0; e_ba = 0; e_rs = 0; e_ts = 0;
      end else begin
        if (busy && act) e_tim = 1;
        if (mrs && !busy && !banks_idle) e_bs = 1;
        if (mrs && !busy && banks_idle && ba != 0) e_ba = 1;
        if (acc && !(blc >= 1 && blc <= 4)) e_rs = 1;
        if (acc && !(rlc == 2 || rlc == 3)) e_rs = 1;
        if (acc && addr[12:7] != 0) e_ts = 1;
      end
      if (acc) begin
        m_valid = 1;
        m_bl = (blc >= 1 && blc <= 4) ? (1 << blc) : 0;
        m_rl = (rlc == 2 || rlc == 3) ? rlc : 0;
        m_bt = addr[3];
      end
      if (m_ph == 1) m_ph = 2;
      else if (m_ph == 2) m_ph = 0;
      else if (acc) m_ph = 1;
      m_ckep = cke;
    end
  end

  task automatic chk(string tag, int act_v, int exp_v);
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic chk_x(string tag, logic [4:0] act_v, int exp_v);
    n_checks++;
    if ($isunknown(act_v) || int'(act_v) != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk_x("R12 mr_valid", {4'b0, mr_valid}, int'(m_valid));
      chk_x("R3 burst_len", burst_len, m_bl);
      chk_x("R4 burst_interleave", {4'b0, burst_interleave}, int'(m_bt));
      chk_x("R5 read_lat", {3'b0, read_lat}, m_rl);
      chk_x("R9 mr_busy", {4'b0, mr_busy}, int'(m_ph != 0));
      chk_x("R11 emr_reset", {4'b0, emr_reset}, int'(m_ph == 2));
      chk_x("R10 err_timing", {4'b0, err_timing}, int'(e_tim));
      chk_x("R8 err_bank_state", {4'b0, err_bank_state}, int'(e_bs));
      chk_x("R7 err_bank_addr", {4'b0, err_bank_addr}, int'(e_ba));
      chk_x("R3 err_reserved", {4'b0, err_reserved}, int'(e_rs));
      chk_x("R6 err_test", {4'b0, err_test}, int'(e_ts));
    end
  end

  task automatic drive(bit c, bit r, bit ca, bit w, logic [12:0] a, logic [1:0] b);
    @(negedge clk); #2;
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; addr = a; ba = b;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) drive(1, 1, 1, 1, '0, '0);
  endtask

  task automatic mrs(logic [12:0] a, logic [1:0] b);
    drive(0, 0, 0, 0, a, b);
  endtask

  initial begin
    #100000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst = 0;
    nop(2);
    // R1: write on the edge where cke first rises is not recognised
    @(negedge clk); #2 cke = 1; cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; addr = 13'h032;
    nop(3);
    chk("R1 no write on cke rise", int'(mr_valid), 0);
    // R2: normal write, BL4 sequential, latency 3
    mrs(13'h032, 2'b00);
    @(negedge clk);
    chk("R2 captured burst_len", int'(burst_len), 4);
    chk("R2 captured read_lat", int'(read_lat), 3);
    nop(3);
    // R10: write in first busy cycle, then read in second
    mrs(13'h023, 2'b00);
    mrs(13'h033, 2'b00);
    drive(0, 1, 0, 1, '0, '0);
    nop(3);
    chk("R10 ignored write kept burst_len", int'(burst_len), 8);
    // R13: sticky then cleared
    nop(2);
    chk("R13 sticky timing", int'(err_timing), 1);
    @(negedge clk); #2 clr_err = 1;
    @(negedge clk); #2 clr_err = 0;
    chk("R13 cleared", int'(err_timing), 0);
    // active command while idle raises nothing
    drive(0, 0, 1, 1, '0, '0);
    nop(2);
    // R8: banks busy
    @(negedge clk); #2 banks_idle = 0; cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; addr = 13'h01B;
    @(negedge clk); #2 banks_idle = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
    nop(1);
    chk("R8 rejected", int'(burst_len), 8);
    // R7: bank address nonzero, each bit
    mrs(13'h02A, 2'b01); nop(2);
    mrs(13'h02A, 2'b10); nop(2);
    chk("R7 rejected", int'(burst_interleave), 0);
    // R3/R5/R6: reserved codes and test bits, accepted
    mrs(13'h080, 2'b00); nop(3);
    mrs(13'h075, 2'b00); nop(3);
    chk("R6 accepted with test bit", int'(mr_valid), 1);
    // R4 and every burst code
    for (int k = 0; k < 8; k++) begin
      mrs(13'(32'h020 | k | ((k & 1) << 3)), 2'b00);
      nop(3);
    end
    // R13: clear wins over a simultaneous set
    mrs(13'h032, 2'b00);
    @(negedge clk); #2 cs_n = 0; ras_n = 1; cas_n = 0; we_n = 0; clr_err = 1;
    @(negedge clk); #2 cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; clr_err = 0;
    chk("R13 clear beats set", int'(err_timing), 0);
    nop(4);
    // cke drop blocks the next write (R1)
    @(negedge clk); #2 cke = 0;
    mrs(13'h012, 2'b00);
    nop(3);
    chk("R1 cke low", int'(burst_len), 4);
    // reset returns outputs to reset state (R12)
    @(negedge clk); #2 rst = 1;
    @(negedge clk); #2 rst = 0; cke = 1;
    nop(2);
    chk("R12 invalid after reset", int'(mr_valid), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule